// File: doc/BRIEF.md
# Frame Delay Trigger Timer

This block times the gap between the end of a modulation pause seen on the carrier and the start of a reply frame. It runs from the carrier-derived clock and counts one step per clock cycle. A low-to-high transition on the external event line, after a two-stage synchronizer, clears the count and starts it again from zero. When the count reaches the programmed delay value (compare A), the trigger output goes high. That rising edge starts the serial transmitter. A second compare value (compare C) drives the trigger low again and leaves the count running.

Both compare values are written through a small write port at run time. A written value waits in a staging register and becomes active only at the next restart, so a frame that is already being timed keeps its values. A single start input restarts the timer together with every other timer on the same command. The count runs upward, stops at its all-ones value, and raises no further compare events until the next restart.

Top module: `fdt_trigger_timer`

## Requirements
- R1: While reset is asserted and after it is released, the trigger output is low. The count is idle, and no compare event occurs until the first restart.
- R2: A one-cycle high on the start input makes the count zero at that clock edge and starts timing.
- R3: The event line passes through two synchronizer flip-flops. A low-to-high transition makes the count zero at the third clock edge after the event is first sampled high.
- R4: While timing, the count rises by exactly one per clock cycle.
- R5: In the cycle after the count equals the active compare A value, the trigger output is high. This includes compare A = 0, which fires one cycle after the restart.
- R6: In the cycle after the count equals the active compare C value, the trigger output is low, unless compare A matches in the same cycle.
- R7: Reaching compare C does not reload or clear the count, so compare A does not fire a second time within the same frame.
- R8: At the all-ones value the count holds, and it raises no compare event until the next restart.
- R9: When compare A and compare C match in the same cycle, the trigger output is set high.
- R10: A write with wr_sel = 0 stages compare A and a write with wr_sel = 1 stages compare C. Staged values become active only at the next restart, and a frame already being timed keeps its values.
- R11: An event line held high causes only one restart.
- R12: The trigger output changes only in the cycle after a compare match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst_n | input | 1 | Active-low reset |
| start_all | input | 1 | Block-wide start command, one-cycle pulse |
| evt_in | input | 1 | Asynchronous end-of-pause event line |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | 0 selects compare A, 1 selects compare C |
| wr_data | input | CNT_W | Compare value to stage |
| trig_out | output | 1 | Frame start trigger |

## Verification
The bench builds the timer with CNT_W = 8 and keeps the two-stage synchronizer. With 8 bits, the saturation point is 255 cycles after a restart. That lets the bench check in a short run that a held count never wraps back onto compare C. The same short delays cover the other corner cases in a few hundred cycles each: compare A of zero, equal compare values, a restart in the middle of a frame, and an event line held high for dozens of cycles.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

  // Write-port selector: which compare value a write stages.
  typedef enum logic {
    SEL_DELAY = 1'b0,
    SEL_CLEAR = 1'b1
  } cmp_sel_e;

  // Compare events raised in one cycle.
  typedef struct packed {
    logic set_ev;
    logic clr_ev;
  } cmp_hit_t;

  // Next trigger level from the current level and this cycle's events.
  // A set event wins over a clear event.
  function automatic logic trig_next(input logic cur, input cmp_hit_t h);
    if (h.set_ev)      return 1'b1;
    else if (h.clr_ev) return 1'b0;
    else               return cur;
  endfunction

endpackage

// File: rtl/fdt_event_sync.sv
module fdt_event_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic evt_edge
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] chain;
  logic         last_q;

  genvar gi;
  generate
    for (gi = 0; gi <= TOP; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= evt_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[TOP];
  end

  assign evt_edge = chain[TOP] & ~last_q;

  // R11: one restart per rising edge, even when the line stays high
  p_single_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_edge |=> !evt_edge);

endmodule

// File: rtl/fdt_counter.sv
module fdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             fresh,
  output logic             running
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return v == CNT_MAX;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return at_top(v) ? v : v + 1'b1;
  endfunction

  logic advance;
  assign advance = running && !at_top(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      fresh   <= 1'b0;
    end else if (restart) begin
      count   <= '0;
      running <= 1'b1;
      fresh   <= 1'b1;
    end else if (advance) begin
      count   <= step(count);
      fresh   <= 1'b1;
    end else begin
      fresh   <= 1'b0;
    end
  end

  // R2/R3: a restart clears the count
  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0) && fresh);

  // R4: one step per cycle while timing
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart && count != CNT_MAX) |=> count == $past(count) + 1'b1);

  // R8: hold at the top with no fresh value
  p_hold_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !restart) |=> (count == CNT_MAX) && !fresh);

  // R1: idle before the first restart
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> !fresh);

endmodule

// File: rtl/fdt_compare.sv
module fdt_compare
  import fdt_pkg::*;
#(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] A_RESET = '1,
  parameter logic [CNT_W-1:0] C_RESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             restart,
  input  logic [CNT_W-1:0] count,
  input  logic             fresh,
  output cmp_hit_t         hit,
  output logic             trig
);
  logic [CNT_W-1:0] stage_a, stage_c;
  logic [CNT_W-1:0] live_a, live_c;

  // Staging registers on the write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= A_RESET;
      stage_c <= C_RESET;
    end else if (wr_en) begin
      if (cmp_sel_e'(wr_sel) == SEL_DELAY) stage_a <= wr_data;
      else                                 stage_c <= wr_data;
    end
  end

  // Active values move over only at a restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_a <= A_RESET;
      live_c <= C_RESET;
    end else if (restart) begin
      live_a <= stage_a;
      live_c <= stage_c;
    end
  end

  assign hit.set_ev = fresh && (count == live_a);
  assign hit.clr_ev = fresh && (count == live_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= trig_next(trig, hit);
  end

  // R5: delay match raises the trigger
  p_set_on_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit.set_ev |=> trig);

  // R6: clear match alone lowers the trigger
  p_clr_on_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.clr_ev && !hit.set_ev) |=> !trig);

  // R9: simultaneous match sets
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.set_ev && hit.clr_ev) |=> trig);

  // R10: active values change only on a restart
  p_live_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(live_a) && $stable(live_c));

  // R12: no trigger change without a match
  p_trig_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit.set_ev && !hit.clr_ev) |=> $stable(trig));

endmodule

// File: rtl/fdt_trigger_timer.sv
module fdt_trigger_timer
  import fdt_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] A_RESET     = '1,
  parameter logic [CNT_W-1:0] C_RESET     = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_all,
  input  logic             evt_in,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             trig_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             evt_edge;
  logic             restart;
  logic [CNT_W-1:0] count;
  logic             fresh;
  logic             running;
  cmp_hit_t         hit;

  fdt_event_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_async(evt_in),
    .evt_edge (evt_edge)
  );

  assign restart = evt_edge | start_all;

  fdt_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .count  (count),
    .fresh  (fresh),
    .running(running)
  );

  fdt_compare #(.CNT_W(CNT_W), .A_RESET(A_RESET), .C_RESET(C_RESET)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .restart(restart),
    .count  (count),
    .fresh  (fresh),
    .hit    (hit),
    .trig   (trig_out)
  );

  // R7: a clear match never reloads the count
  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.clr_ev && !restart && count != CNT_MAX) |=> count != '0);

  // R8: no compare event while holding at the top
  p_no_event_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !restart) |=> !hit.set_ev && !hit.clr_ev);

endmodule

// File: tb/test_fdt_trigger_timer.sv
module test_fdt_trigger_timer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_all = 1'b0;
  logic         evt_in = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         trig_out;

  always #4 clk = ~clk;

  fdt_trigger_timer #(.CNT_W(W)) i_fdt_trigger_timer (
    .clk(clk), .rst_n(rst_n), .start_all(start_all), .evt_in(evt_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .trig_out(trig_out)
  );

  typedef struct {
    int    at;
    logic  lvl;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  logic  exp_lvl = 1'b0;
  logic  armed = 1'b0;
  logic  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d trig actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  // Monitor: pop expected transitions, otherwise confirm the level holds
  always @(negedge clk) begin
    if (armed) begin
      if (q.size() > 0 && q[0].at == cyc) begin
        exp_lvl = q[0].lvl;
        check(q[0].tag, trig_out, exp_lvl);
        void'(q.pop_front());
      end else begin
        check("R12 steady", trig_out, exp_lvl);
      end
    end
  end

  task automatic push(input int at, input logic lvl, input string tag);
    exp_t e;
    e.at = at; e.lvl = lvl; e.tag = tag;
    q.push_back(e);
  endtask

  // Expected transitions for a frame whose count is zero at edge r
  task automatic expect_frame(input int r, input int a, input int c,
                              input string ta, input string tc);
    if (a == c) push(r + a + 1, 1'b1, "R9 equal compares");
    else if (a < c) begin
      push(r + a + 1, 1'b1, ta);
      push(r + c + 1, 1'b0, tc);
    end else begin
      push(r + c + 1, 1'b0, tc);
      push(r + a + 1, 1'b1, ta);
    end
  endtask

  task automatic wr(input logic sel, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start_frame(input int a, input int c, output int r);
    @(negedge clk);
    r = cyc + 1;
    start_all = 1'b1;
    expect_frame(r, a, c, "R2/R5 start then set", "R6 clear");
    @(negedge clk);
    start_all = 1'b0;
  endtask

  task automatic evt_frame(input int a, input int c, input int hold,
                           input logic do_push, input string ta, output int r);
    @(negedge clk);
    r = cyc + 3;
    evt_in = 1'b1;
    if (do_push) expect_frame(r, a, c, ta, "R6 clear");
    repeat (hold) @(negedge clk);
    evt_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    int r2;
    repeat (3) @(negedge clk);
    check("R1 reset low", trig_out, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle after reset", trig_out, 1'b0);
    armed = 1'b1;

    // R2: start command
    wr(1'b0, 20); wr(1'b1, 40);
    start_frame(20, 40, r);
    wait_to(r + 50);

    // R3: event restart
    wr(1'b0, 10); wr(1'b1, 25);
    evt_frame(10, 25, 3, 1'b1, "R3/R5 event then set", r);
    wait_to(r + 35);

    // R4: restart in mid-frame, only the second frame fires
    wr(1'b0, 20); wr(1'b1, 35);
    evt_frame(20, 35, 2, 1'b0, "", r);
    wait_to(r + 8);
    evt_frame(20, 35, 2, 1'b1, "R4 mid-frame restart", r2);
    wait_to(r2 + 45);

    // R10: writes during a frame wait for the next restart
    wr(1'b0, 30); wr(1'b1, 45);
    evt_frame(30, 45, 2, 1'b1, "R10 old values kept", r);
    wait_to(r + 3);
    wr(1'b0, 5); wr(1'b1, 12);
    wait_to(r + 55);
    evt_frame(5, 12, 2, 1'b1, "R10 new values active", r);
    wait_to(r + 20);

    // R7: clear match does not reload the count
    wr(1'b0, 10); wr(1'b1, 20);
    evt_frame(10, 20, 2, 1'b1, "R7 single set", r);
    wait_to(r + 90);
    check("R7 no second set", trig_out, 1'b0);

    // R5: zero delay
    wr(1'b0, 0); wr(1'b1, 3);
    evt_frame(0, 3, 2, 1'b1, "R5 zero delay", r);
    wait_to(r + 10);

    // R11: held event line gives one restart
    wr(1'b0, 8); wr(1'b1, 16);
    evt_frame(8, 16, 50, 1'b1, "R11 held line", r);
    wait_to(r + 80);
    check("R11 no extra frame", trig_out, 1'b0);

    // R9: equal compares set
    wr(1'b0, 15); wr(1'b1, 15);
    evt_frame(15, 15, 2, 1'b1, "R9", r);
    wait_to(r + 25);
    check("R9 stays high", trig_out, 1'b1);

    // R8: saturation, no wrap onto compare C
    wr(1'b0, 250); wr(1'b1, 10);
    evt_frame(250, 10, 2, 1'b1, "R8 late set", r);
    wait_to(r + 300);
    check("R8 held high at top", trig_out, 1'b1);

    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R12 %0d expected transitions not seen (expected 0)", q.size());
    end
    done = 1'b1;
    armed = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule